// File: doc/BRIEF.md
# Three-Voice Square-Wave Sound Generator

This block synthesises audio from fourteen byte-wide control registers. Three square-wave voices, a shared pseudo-random noise source and an envelope shaper are combined by a per-voice gate. Each voice then picks a fixed or envelope-driven loudness, which is mapped through a logarithmic level table. The three voice levels are added into one signed 16-bit mono sample on every pulse of the sample-enable input `tick`.

A host writes registers through an address/data/strobe port. Writes land in a shadow copy and only reach the generator at a sample boundary. While `bulk` is high, the shadow is sealed off from the generator, so a group of writes goes live together at the first tick after `bulk` falls. A staging state machine tracks this with three named states. `ST_IDLE` means no write is waiting. `ST_PEND` means staged writes will commit on the next tick. `ST_BULK` means commits are withheld. Its transitions are:
- idle-to-pend on an accepted write;
- pend-to-idle on a tick with no new write;
- any-to-bulk while `bulk` is high;
- bulk-to-pend when `bulk` falls with writes waiting;
- bulk-to-idle when `bulk` falls with nothing waiting.

The synchronous clear input `clr` empties both register copies and all generator state, which silences the output.

Top module: `psg_core`

## Requirements
- R1: `rst_n` low or `clr` high zeroes every register, shadow entry and generator state. The LFSR is the exception and takes the seed 1. Every sample produced afterwards is 0 until registers are written.
- R2: A write to register index 0..13 changes the output only from the sample produced by the next `tick`, and that sample already uses the new value. Writes to indices 14 and 15 are discarded and change nothing.
- R3: While `bulk` is high, ticks use the previously committed registers. All writes staged meanwhile take effect together at the first tick after `bulk` returns low.
- R4: Voice k (A=0, B=1, C=2) has a 12-bit period P. Its low byte is register 2k and its upper four bits are the low nibble of register 2k+1; the upper nibble of 2k+1 is ignored, and a period of 0 acts as 1. After a clear, the first tick reports phase 0 and then flips it. After that, each phase level lasts P ticks.
- R5: The noise period is bits [4:0] of register 6 (0 acts as 1) and is counted like a voice period. The noise bit is bit 0 of a 17-bit LFSR seeded to 1. On each expiry the LFSR shifts right and bit0 XOR bit3 enters bit 16.
- R6: Register 7 holds the gate controls. Bits 0..2 force the tone term of voices A..C on, and bits 3..5 do the same for the noise term. Gate k = (tone_k OR bit k) AND (noise OR bit 3+k).
- R7: For registers 8..10 (voices A..C), bit 4 set selects the envelope level as the loudness. Bit 4 clear selects bits [3:0]. Bits [7:5] are ignored.
- R8: The envelope step period is {register 12, register 11} (0 acts as 1). Register 13 holds the shape: bit 3 continue, bit 2 attack (rising), bit 1 alternate, bit 0 hold. Committing a write to register 13 restarts the envelope at level 0 (attack) or 15 (decay), and the level steps on each expiry. After 16 levels, three outcomes are possible. Without continue, the level drops to 0 and stays there. With continue and hold, it freezes at the final level, inverted if alternate is set. Otherwise it repeats, reversing direction when alternate is set.
- R9: Each tick yields, one clock later with `sample_vld` high for one cycle, the sum over voices of gate_k × V(loudness_k). Here V(0)=0 and V(n)=round(10000·2^((n−15)/2)), giving 78, 110, 156, 221, 313, 442, 625, 884, 1250, 1768, 2500, 3536, 5000, 7071, 10000 for n=1..15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of registers and generator state |
| tick | input | 1 | Sample enable, one pulse per output sample |
| bulk | input | 1 | Holds staged writes back until it falls |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index |
| wr_data | input | 8 | Register value |
| sample_out | output | 16 | Signed mono sample |
| sample_vld | output | 1 | High for one cycle when sample_out is new |

## Verification
The assertions assume `tick` and `wr_en` never fall in the same cycle as each other. They also assume `tick` is never high while `bulk` rises from a pending state, so every staged write has an unambiguous commit tick. The bench drives writes, ticks and `bulk` changes in separate cycles, each on its own negative edge. It issues a `clr` before each directed test, so the tone, noise and envelope sequences start from the known state R1 defines.

// File: rtl/psg_pkg.sv
package psg_pkg;
    localparam int NREG    = 14;
    localparam int AW      = 4;
    localparam int NCH     = 3;
    localparam int TONE_W  = 12;
    localparam int NOISE_W = 5;
    localparam int ENV_W   = 16;
    localparam int LFSR_W  = 17;
    localparam int SMP_W   = 16;
    localparam int ACC_W   = SMP_W + 2;

    localparam int RG_NPER  = 6;
    localparam int RG_GATE  = 7;
    localparam int RG_AMP0  = 8;
    localparam int RG_EPLO  = 11;
    localparam int RG_EPHI  = 12;
    localparam int RG_SHAPE = 13;

    localparam logic [LFSR_W-1:0] LFSR_SEED = LFSR_W'(1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PEND,
        ST_BULK
    } stage_st_e;

    function automatic logic [SMP_W-1:0] vol_lut(input logic [3:0] lvl);
        logic [SMP_W-1:0] v;
        case (lvl)
            4'd0:  v = 16'd0;
            4'd1:  v = 16'd78;
            4'd2:  v = 16'd110;
            4'd3:  v = 16'd156;
            4'd4:  v = 16'd221;
            4'd5:  v = 16'd313;
            4'd6:  v = 16'd442;
            4'd7:  v = 16'd625;
            4'd8:  v = 16'd884;
            4'd9:  v = 16'd1250;
            4'd10: v = 16'd1768;
            4'd11: v = 16'd2500;
            4'd12: v = 16'd3536;
            4'd13: v = 16'd5000;
            4'd14: v = 16'd7071;
            default: v = 16'd10000;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/psg_stage.sv
module psg_stage
    import psg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  tick,
    input  logic                  bulk,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [7:0]            wr_data,
    output logic [NREG-1:0][7:0]  regs_eff,
    output logic                  commit,
    output logic                  env_restart
);
    stage_st_e st_q, st_d;
    logic [NREG-1:0][7:0] shd_q, live_q;
    logic [NREG-1:0]      dirty_q, wr_bit;
    logic                 wr_ok;

    assign wr_ok  = wr_en && (wr_addr < AW'(NREG));
    assign wr_bit = wr_ok ? (NREG'(1) << wr_addr) : '0;

    // next-state process
    always_comb begin
        st_d = st_q;
        if (bulk) begin
            st_d = ST_BULK;
        end else begin
            unique case (st_q)
                ST_IDLE: if (wr_ok) st_d = ST_PEND;
                ST_PEND: if (tick && !wr_ok) st_d = ST_IDLE;
                ST_BULK: st_d = (|dirty_q || wr_ok) ? ST_PEND : ST_IDLE;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // output process
    always_comb begin
        commit      = tick && (st_q == ST_PEND);
        regs_eff    = commit ? shd_q : live_q;
        env_restart = commit && dirty_q[RG_SHAPE];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            shd_q   <= '0;
            live_q  <= '0;
            dirty_q <= '0;
        end else if (clr) begin
            st_q    <= ST_IDLE;
            shd_q   <= '0;
            live_q  <= '0;
            dirty_q <= '0;
        end else begin
            st_q <= st_d;
            if (wr_ok) shd_q[wr_addr] <= wr_data;
            if (commit) live_q <= shd_q;
            dirty_q <= (commit ? '0 : dirty_q) | wr_bit;
        end
    end

    p_clr_empties_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (live_q == '0 && shd_q == '0 && st_q == ST_IDLE));
    p_idle_nothing_waiting_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> (dirty_q == '0));
    p_bulk_freezes_live_r3: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (st_q == ST_BULK) |=> $stable(live_q));
endmodule

// File: rtl/psg_div.sv
module psg_div #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic         restart,
    input  logic [W-1:0] period,
    output logic         fire
);
    logic [W-1:0] cnt_q, cur, peff;

    assign peff = (period == '0) ? W'(1) : period;
    assign cur  = restart ? '0 : cnt_q;
    assign fire = tick && (cur <= W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr)   cnt_q <= '0;
        else if (tick)  cnt_q <= fire ? peff : cur - W'(1);
    end

    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n || clr)
        fire |=> (cnt_q == $past(peff)));
    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (tick && !fire && !restart) |=> (cnt_q == $past(cnt_q) - W'(1)));
endmodule

// File: rtl/psg_noise.sv
module psg_noise
    import psg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               tick,
    input  logic [NOISE_W-1:0] period,
    output logic               nbit
);
    logic              nfire;
    logic [LFSR_W-1:0] lfsr_q;

    psg_div #(.W(NOISE_W)) u_ndiv (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
        .restart(1'b0), .period(period), .fire(nfire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lfsr_q <= LFSR_SEED;
        else if (clr)    lfsr_q <= LFSR_SEED;
        else if (nfire)  lfsr_q <= {lfsr_q[0] ^ lfsr_q[3], lfsr_q[LFSR_W-1:1]};
    end

    assign nbit = lfsr_q[0];

    p_lfsr_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);
    p_lfsr_idle_r5: assert property (@(posedge clk) disable iff (!rst_n || clr)
        !nfire |=> $stable(lfsr_q));
endmodule

// File: rtl/psg_env.sv
module psg_env
    import psg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             restart,
    input  logic [ENV_W-1:0] period,
    input  logic [3:0]       shape,
    output logic [3:0]       level
);
    logic       efire;
    logic [3:0] step_q, step_d, cur_step;
    logic       inv_q, inv_d, cur_inv;
    logic       held_q, held_d, cur_held;
    logic       zero_q, zero_d, cur_zero;
    logic       sh_cont, sh_att, sh_alt, sh_hold;

    assign {sh_cont, sh_att, sh_alt, sh_hold} = shape;

    psg_div #(.W(ENV_W)) u_ediv (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
        .restart(restart), .period(period), .fire(efire)
    );

    always_comb begin
        cur_step = restart ? 4'd0    : step_q;
        cur_inv  = restart ? !sh_att : inv_q;
        cur_held = restart ? 1'b0    : held_q;
        cur_zero = restart ? 1'b0    : zero_q;
        level    = cur_zero ? 4'd0 : (cur_inv ? ~cur_step : cur_step);
    end

    always_comb begin
        step_d = cur_step;
        inv_d  = cur_inv;
        held_d = cur_held;
        zero_d = cur_zero;
        if (efire && !cur_held) begin
            if (cur_step != 4'hF) begin
                step_d = cur_step + 4'd1;
            end else if (!sh_cont) begin
                held_d = 1'b1;
                zero_d = 1'b1;
            end else if (sh_hold) begin
                held_d = 1'b1;
                inv_d  = cur_inv ^ sh_alt;
            end else begin
                step_d = 4'd0;
                inv_d  = cur_inv ^ sh_alt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || clr) begin
            step_q <= '0;
            inv_q  <= 1'b1;
            held_q <= 1'b0;
            zero_q <= 1'b0;
        end else if (tick) begin
            step_q <= step_d;
            inv_q  <= inv_d;
            held_q <= held_d;
            zero_q <= zero_d;
        end
    end

    p_held_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (held_q && !restart) |=> ($stable(step_q) && $stable(inv_q)));
    p_restart_from_start_r8: assert property (@(posedge clk) disable iff (!rst_n || clr)
        restart |=> (!zero_q && step_q <= 4'd1));
endmodule

// File: rtl/psg_core.sv
module psg_core
    import psg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    input  logic              bulk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [7:0]        wr_data,
    output logic [SMP_W-1:0]  sample_out,
    output logic              sample_vld
);
    logic [NREG-1:0][7:0] regs;
    logic                 commit, env_restart;
    logic                 nbit;
    logic [3:0]           env_lvl;
    logic [NCH-1:0]       phase_q, tfire, gate;
    logic [SMP_W-1:0]     vol [NCH];
    logic [ACC_W-1:0]     acc;
    logic                 unused_bits;

    psg_stage u_stage (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .bulk(bulk),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .regs_eff(regs), .commit(commit), .env_restart(env_restart)
    );

    psg_noise u_noise (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
        .period(regs[RG_NPER][NOISE_W-1:0]), .nbit(nbit)
    );

    psg_env u_env (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .restart(env_restart),
        .period({regs[RG_EPHI], regs[RG_EPLO]}), .shape(regs[RG_SHAPE][3:0]),
        .level(env_lvl)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_voice
        logic [3:0] amp;

        psg_div #(.W(TONE_W)) u_tdiv (
            .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .restart(1'b0),
            .period({regs[2*k+1][TONE_W-9:0], regs[2*k]}), .fire(tfire[k])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        phase_q[k] <= 1'b0;
            else if (clr)      phase_q[k] <= 1'b0;
            else if (tfire[k]) phase_q[k] <= ~phase_q[k];
        end

        always_comb begin
            gate[k] = (phase_q[k] | regs[RG_GATE][k]) & (nbit | regs[RG_GATE][NCH+k]);
            amp     = regs[RG_AMP0+k][4] ? env_lvl : regs[RG_AMP0+k][3:0];
            vol[k]  = gate[k] ? vol_lut(amp) : '0;
        end
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < NCH; k++) acc = acc + ACC_W'(vol[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || clr) begin
            sample_out <= '0;
            sample_vld <= 1'b0;
        end else begin
            sample_vld <= tick;
            if (tick) sample_out <= acc[SMP_W-1:0];
        end
    end

    assign unused_bits = ^{regs[1][7:4], regs[3][7:4], regs[5][7:4], regs[RG_NPER][7:5],
                           regs[RG_GATE][7:6], regs[8][7:5], regs[9][7:5], regs[10][7:5],
                           regs[RG_SHAPE][7:4], commit};

    p_vld_after_tick_r9: assert property (@(posedge clk) disable iff (!rst_n || clr)
        tick |=> sample_vld);
    p_vld_only_after_tick_r9: assert property (@(posedge clk) disable iff (!rst_n || clr)
        !tick |=> !sample_vld);
    p_sample_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(sample_out) >= 0) && ($signed(sample_out) <= 30000));
    p_held_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n || clr)
        !tick |=> $stable(sample_out));
endmodule

// File: tb/tb_psg_core.sv
module tb_psg_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        tick = 1'b0;
    logic        bulk = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] sample_out;
    logic        sample_vld;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    psg_core dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .bulk(bulk),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sample_out(sample_out), .sample_vld(sample_vld)
    );

    function automatic int vtab(input int n);
        case (n)
            0: return 0;     1: return 78;    2: return 110;   3: return 156;
            4: return 221;   5: return 313;   6: return 442;   7: return 625;
            8: return 884;   9: return 1250;  10: return 1768; 11: return 2500;
            12: return 3536; 13: return 5000; 14: return 7071; default: return 10000;
        endcase
    endfunction

    function automatic logic [16:0] lfsr_next(input logic [16:0] s);
        return {s[0] ^ s[3], s[16:1]};
    endfunction

    task automatic chk(input int req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_tick(output int s);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        s = int'(sample_out);
        if (!sample_vld) begin
            n_chk++; n_bad++;
            $display("FAIL R9 sample_vld: actual 0 expected 1");
        end
    endtask

    task automatic do_clr();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    // {req[3:0], kind[1:0], addr[3:0], data[7:0], expected[15:0]}
    // kind 0 write, 1 tick and compare, 2 bulk high, 3 bulk low
    localparam int NV = 23;
    localparam logic [33:0] VEC [NV] = '{
        {4'd1, 2'd1, 4'd0,  8'h00, 16'd0},      // R1 silent after clear
        {4'd6, 2'd0, 4'd7,  8'h3F, 16'd0},
        {4'd6, 2'd1, 4'd0,  8'h00, 16'd0},      // R6 gates open, loudness 0
        {4'd2, 2'd0, 4'd8,  8'h0F, 16'd0},
        {4'd2, 2'd1, 4'd0,  8'h00, 16'd10000},  // R2 applied at next tick
        {4'd9, 2'd0, 4'd9,  8'h08, 16'd0},
        {4'd9, 2'd1, 4'd0,  8'h00, 16'd10884},  // R9 sum of two voices
        {4'd9, 2'd0, 4'd10, 8'h01, 16'd0},
        {4'd9, 2'd1, 4'd0,  8'h00, 16'd10962},
        {4'd2, 2'd0, 4'd14, 8'hFF, 16'd0},      // R2 index 14 discarded
        {4'd2, 2'd1, 4'd0,  8'h00, 16'd10962},
        {4'd2, 2'd0, 4'd15, 8'h1F, 16'd0},      // R2 index 15 discarded
        {4'd2, 2'd1, 4'd0,  8'h00, 16'd10962},
        {4'd3, 2'd2, 4'd0,  8'h00, 16'd0},
        {4'd3, 2'd0, 4'd8,  8'h00, 16'd0},
        {4'd3, 2'd1, 4'd0,  8'h00, 16'd10962},  // R3 withheld during bulk
        {4'd3, 2'd0, 4'd9,  8'h0F, 16'd0},
        {4'd3, 2'd1, 4'd0,  8'h00, 16'd10962},
        {4'd3, 2'd3, 4'd0,  8'h00, 16'd0},
        {4'd3, 2'd1, 4'd0,  8'h00, 16'd10078},  // R3 both land together
        {4'd7, 2'd0, 4'd10, 8'h0C, 16'd0},
        {4'd7, 2'd1, 4'd0,  8'h00, 16'd13536},
        {4'd7, 2'd1, 4'd0,  8'h00, 16'd13536}   // R7 fixed loudness holds
    };

    initial begin
        #1_800_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int s;
        repeat (3) @(negedge clk);
        chk(1, "reset sample_out", int'(sample_out), 0);
        chk(1, "reset sample_vld", int'(sample_vld), 0);
        rst_n = 1'b1;
        do_clr();

        // table walk: staging, bulk, fixed loudness, summing
        for (int i = 0; i < NV; i++) begin
            logic [33:0] v;
            v = VEC[i];
            case (v[29:28])
                2'd0: wr(int'(v[27:24]), int'(v[23:16]));
                2'd1: begin
                    do_tick(s);
                    chk(int'(v[33:30]), $sformatf("vector %0d", i), s, int'(v[15:0]));
                end
                2'd2: begin @(negedge clk); bulk = 1'b1; end
                default: begin @(negedge clk); bulk = 1'b0; end
            endcase
        end
        wr(8, 8'h2F);                            // R7 bits 7:5 ignored
        do_tick(s);
        chk(7, "upper bits ignored", s, 10000 + 10000 + 3536);

        // R1: clear drops staged and committed values
        wr(7, 8'h3F);
        wr(8, 8'h0F);
        do_clr();
        do_tick(s);
        chk(1, "after clear", s, 0);
        wr(7, 8'h3F);
        do_tick(s);
        chk(1, "loudness cleared", s, 0);

        // R4: voice A, period 3, high nibble of reg 1 ignored
        do_clr();
        wr(0, 8'h03); wr(1, 8'hF0); wr(7, 8'h3E); wr(8, 8'h0F);
        begin
            int exp_ph [10] = '{0, 1, 1, 1, 0, 0, 0, 1, 1, 1};
            for (int i = 0; i < 10; i++) begin
                do_tick(s);
                chk(4, $sformatf("voice A tick %0d", i), s, exp_ph[i] * 10000);
            end
        end

        // R4: voice C, 12-bit period 0x102
        do_clr();
        wr(4, 8'h02); wr(5, 8'hF1); wr(7, 8'h3B); wr(10, 8'h0F);
        for (int i = 0; i < 260; i++) begin
            do_tick(s);
            if (i == 0 || i == 259) chk(4, $sformatf("voice C tick %0d", i), s, 0);
            if (i == 1 || i == 258) chk(4, $sformatf("voice C tick %0d", i), s, 10000);
        end

        // R5: noise only on voice A, noise period 2 (upper bits of reg 6 ignored)
        do_clr();
        wr(6, 8'hE2); wr(7, 8'h37); wr(8, 8'h0F);
        begin
            logic [16:0] lf = 17'd1;
            int cnt = 0;
            for (int i = 0; i < 40; i++) begin
                do_tick(s);
                chk(5, $sformatf("noise tick %0d", i), s, lf[0] ? 10000 : 0);
                if (cnt <= 1) begin lf = lfsr_next(lf); cnt = 2; end
                else cnt--;
            end
        end

        // R6: tone and noise both gating voice A, periods 0 (act as 1)
        do_clr();
        wr(7, 8'h36); wr(8, 8'h0F);
        begin
            logic [16:0] lf = 17'd1;
            int ph = 0;
            for (int i = 0; i < 24; i++) begin
                do_tick(s);
                chk(6, $sformatf("and gate tick %0d", i), s, (ph == 1 && lf[0]) ? 10000 : 0);
                ph = 1 - ph;
                lf = lfsr_next(lf);
            end
        end

        // R8: attack, no continue -> ramp then 0
        do_clr();
        wr(7, 8'h3F); wr(8, 8'h10); wr(11, 8'h01); wr(12, 8'h00); wr(13, 8'h04);
        for (int i = 0; i < 18; i++) begin
            do_tick(s);
            chk(8, $sformatf("env one-shot tick %0d", i), s, vtab(i < 16 ? i : 0));
        end
        // R8: triangle (continue, attack, alternate), period 0 acts as 1
        wr(11, 8'h00); wr(13, 8'h0E);
        for (int i = 0; i < 34; i++) begin
            int e;
            e = (i < 16) ? i : (i < 32) ? 31 - i : i - 32;
            do_tick(s);
            chk(8, $sformatf("env triangle tick %0d", i), s, vtab(e));
        end
        // R8: continue+attack+hold, period 2 -> freeze at 15
        wr(11, 8'h02); wr(13, 8'h0D);
        for (int i = 0; i < 36; i++) begin
            int e;
            e = (i + 1) / 2;
            if (e > 15) e = 15;
            do_tick(s);
            chk(8, $sformatf("env hold tick %0d", i), s, vtab(e));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule